// File: doc/BRIEF.md
# FM Clock/Data Window Separator

This block takes the raw read pulse train from a disk or tape head channel, recorded in FM (one clock pulse per bit cell, plus a data pulse in the middle of the cell for a one), and sorts each pulse into a clock stream or a data stream according to the timing window it lands in. A pulse accepted as a clock opens a data window. The length of that window, counted in system clock cycles, is one of two programmable values. The short value applies when the previous cell carried a one and the long value when it carried a zero. All other time belongs to the clock window.

When the data window closes, the block reports the recovered bit with a one-cycle strobe. That bit then selects the next window length. A separated data pulse that is still being output holds the window open until the pulse ends. The raw input is asynchronous. It is synchronised and edge-detected, so each rising edge counts as exactly one event. One cycle follows each window close in which neither window is open. A pulse that lands in that cycle is discarded and counted. If no clock pulse arrives within the programmed cell length, the separator falls back to its reset assumption that the last bit was a zero.

Top module: `fm_window_separator`

## Requirements
- R1: After reset the clock window output is 1, the data window output is 0, both separated pulse outputs and the bit strobe are 0, and the drop counter is 0.
- R2: A read edge that reaches the core while the clock window is open produces a one-cycle separated clock pulse. On the same edge the data window opens and the clock window closes.
- R3: With no data pulse reaching past its end, the data window stays open for exactly short_len_i cycles if the previous recovered bit was 1, and exactly long_len_i cycles if it was 0 (0 after reset).
- R4: A read edge that reaches the core while the data window is open produces a separated data pulse PULSE_LEN cycles wide and marks the current cell as holding a one.
- R5: Every separated clock pulse clears the cell's data mark, so a cell without a data pulse yields bit 0 even after a cell holding a one.
- R6: If a data pulse starts in the last cycle of the data window, the window stays open until the pulse's last cycle. The window is then short_len/long_len plus PULSE_LEN cycles long.
- R7: When the data window closes, one cycle follows with neither window open. In that cycle bit_valid_o is 1 for exactly one cycle and bit_o carries the cell's data mark. After it the clock window opens.
- R8: A read edge that reaches the core in the cycle with neither window open produces no separated pulse and raises err_cnt_o by one. The counter saturates at 2^ERR_W-1.
- R9: If no clock pulse is accepted within cell_len_i cycles after the last separated clock pulse, the previous-bit state returns to 0, so the next data window uses long_len_i.
- R10: The raw input passes through SYNC_FF flops and only its rising edge is an event. A level held high across several windows gives a single separated pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_raw_i | input | 1 | Asynchronous raw read pulse |
| short_len_i | input | CNT_W | Data window length after a one, in cycles |
| long_len_i | input | CNT_W | Data window length after a zero, in cycles |
| cell_len_i | input | CNT_W | Cycles without a clock before falling back to the reset bit state |
| sep_clk_o | output | 1 | Separated clock pulse, one cycle |
| sep_data_o | output | 1 | Separated data pulse, PULSE_LEN cycles |
| clk_win_o | output | 1 | Clock window open |
| data_win_o | output | 1 | Data window open |
| bit_o | output | 1 | Recovered bit of the last closed cell |
| bit_valid_o | output | 1 | One-cycle strobe for bit_o |
| err_cnt_o | output | ERR_W | Saturating count of dropped pulses |

## Verification
The two functions that can meet in one cycle are the expiry of the window timer and the arrival of a data pulse, which starts the hold-open path. The bench watches data_win_o rise and then places the read edge so that it reaches the core exactly in the window's last cycle, under both the short and the long length. A scoreboard judges the outcome. It expects a data pulse, then a recovered one, with a window of the programmed length plus PULSE_LEN, and no drop count. A companion case moves the edge one cycle later, into the closing cycle, and expects a drop instead.

// File: rtl/fm_sep_pkg.sv
package fm_sep_pkg;
  typedef enum logic [1:0] {
    ST_CLKW = 2'd0,
    ST_DATW = 2'd1,
    ST_GAP  = 2'd2
  } sep_state_t;

  localparam int N_WIN   = 2;
  localparam int WIN_SHORT = 0;
  localparam int WIN_LONG  = 1;
endpackage

// File: rtl/fm_rd_sync.sv
module fm_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic event_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= (sh_q << 1) | STAGES'(raw_i);
      last_q <= sh_q[STAGES-1];
    end
  end

  assign event_o = sh_q[STAGES-1] & ~last_q;

  // R10: a detected event is never followed by another in the next cycle
  a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);
endmodule

// File: rtl/fm_win_timer.sv
module fm_win_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)       cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // more than one cycle of window remains
  assign run_o = cnt_q > CNT_W'(1);

  // R9: a timer held in reset does not run in the following cycle
  a_r9_clr_idle: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !run_o);
endmodule

// File: rtl/fm_window_separator.sv
module fm_window_separator #(
  parameter int CNT_W     = 8,
  parameter int ERR_W     = 4,
  parameter int SYNC_FF   = 2,
  parameter int PULSE_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_raw_i,
  input  logic [CNT_W-1:0] short_len_i,
  input  logic [CNT_W-1:0] long_len_i,
  input  logic [CNT_W-1:0] cell_len_i,
  output logic             sep_clk_o,
  output logic             sep_data_o,
  output logic             clk_win_o,
  output logic             data_win_o,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  import fm_sep_pkg::*;

  localparam int         HOLD_W  = $clog2(PULSE_LEN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  sep_state_t        state_q;
  logic              ev;
  logic              prev_bit_q;
  logic              dmark_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cell_q;
  logic              cell_run_q;
  logic [N_WIN-1:0]  tmr_run;
  logic              win_run;
  logic              start;

  fm_rd_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .raw_i(rd_raw_i), .event_o(ev)
  );

  assign start = (state_q == ST_CLKW) && ev;

  for (genvar i = 0; i < N_WIN; i++) begin : g_tmr
    logic clr_w;
    // the timer not picked by the previous bit is held in reset
    assign clr_w = (i == WIN_SHORT) ? !prev_bit_q : prev_bit_q;
    fm_win_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .clr_i(clr_w), .load_i(start && !clr_w),
      .len_i((i == WIN_SHORT) ? short_len_i : long_len_i),
      .run_o(tmr_run[i])
    );
  end

  assign win_run = |tmr_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_CLKW;
      prev_bit_q  <= 1'b0;
      dmark_q     <= 1'b0;
      hold_q      <= '0;
      cell_q      <= '0;
      cell_run_q  <= 1'b0;
      sep_clk_o   <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      err_cnt_o   <= '0;
    end else begin
      sep_clk_o   <= 1'b0;
      bit_valid_o <= 1'b0;
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (cell_run_q && cell_q != cell_len_i) cell_q <= cell_q + 1'b1;
      case (state_q)
        ST_CLKW: begin
          if (ev) begin
            sep_clk_o  <= 1'b1;
            dmark_q    <= 1'b0;
            state_q    <= ST_DATW;
            cell_q     <= '0;
            cell_run_q <= 1'b1;
          end else if (cell_run_q && cell_q == cell_len_i) begin
            prev_bit_q <= 1'b0;
            cell_run_q <= 1'b0;
          end
        end
        ST_DATW: begin
          if (ev) begin
            hold_q  <= HOLD_W'(PULSE_LEN);
            dmark_q <= 1'b1;
          end else if (!win_run && hold_q <= HOLD_W'(1)) begin
            state_q     <= ST_GAP;
            bit_o       <= dmark_q;
            bit_valid_o <= 1'b1;
            prev_bit_q  <= dmark_q;
          end
        end
        ST_GAP: begin
          state_q <= ST_CLKW;
          if (ev && err_cnt_o != ERR_MAX) err_cnt_o <= err_cnt_o + 1'b1;
        end
        default: state_q <= ST_CLKW;
      endcase
    end
  end

  assign clk_win_o  = (state_q == ST_CLKW);
  assign data_win_o = (state_q == ST_DATW);
  assign sep_data_o = (hold_q != '0);

  // R2: a separated clock pulse coincides with an open data window
  a_r2_clk_opens_data: assert property (@(posedge clk) disable iff (rst)
    sep_clk_o |-> data_win_o && !clk_win_o);
  // R3: only the selected window timer ever counts
  a_r3_one_timer: assert property (@(posedge clk) disable iff (rst)
    !(tmr_run[WIN_SHORT] && tmr_run[WIN_LONG]));
  // R6: a separated data pulse never extends outside the data window
  a_r6_data_in_window: assert property (@(posedge clk) disable iff (rst)
    sep_data_o |-> data_win_o);
  // R7: the bit strobe is one cycle wide and falls in the gap
  a_r7_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    bit_valid_o |-> !clk_win_o && !data_win_o);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    bit_valid_o |=> !bit_valid_o && clk_win_o);
  // R8: the drop counter steps by one and sticks at its ceiling
  a_r8_err_step: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));
  a_r8_err_sat: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o == ERR_MAX) |=> (err_cnt_o == ERR_MAX));
endmodule

// File: tb/fm_window_separator_tb.sv
module fm_window_separator_tb;
  localparam int CNT_W = 8, ERR_W = 2, SYNC_FF = 2, PULSE_LEN = 2;
  localparam int SHORT = 6, LONG = 10, CELL = 28;
  localparam int EV_C = 1, EV_D = 2, EV_B0 = 3, EV_B1 = 4, EV_E = 5;

  logic clk = 1'b0, rst = 1'b1, rd = 1'b0;
  logic sep_clk, sep_data, clk_win, data_win, bit_q, bit_valid;
  logic [ERR_W-1:0] err_cnt;

  int errors = 0, checks = 0;
  int evq[$];
  int wq[$];
  bit model_prev = 1'b0;
  int model_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fm_window_separator #(.CNT_W(CNT_W), .ERR_W(ERR_W), .SYNC_FF(SYNC_FF),
                        .PULSE_LEN(PULSE_LEN)) u_dut (
    .clk(clk), .rst(rst), .rd_raw_i(rd),
    .short_len_i(CNT_W'(SHORT)), .long_len_i(CNT_W'(LONG)), .cell_len_i(CNT_W'(CELL)),
    .sep_clk_o(sep_clk), .sep_data_o(sep_data), .clk_win_o(clk_win),
    .data_win_o(data_win), .bit_o(bit_q), .bit_valid_o(bit_valid), .err_cnt_o(err_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expectations as results appear
  logic p_clk = 0, p_data = 0, p_win = 0;
  logic [ERR_W-1:0] p_err = '0;
  int win_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sep_clk && !p_clk) begin
        check("R2 window opens with clock", int'(data_win), 1);
        if (evq.size() == 0) check("R2 unexpected clock", EV_C, 0);
        else check("R2/R10 clock event", EV_C, evq.pop_front());
      end
      if (sep_data && !p_data) begin
        if (evq.size() == 0) check("R4 unexpected data", EV_D, 0);
        else check("R4 data event", EV_D, evq.pop_front());
      end
      if (bit_valid) begin
        check("R7 gap has no window", int'(clk_win || data_win), 0);
        if (evq.size() == 0) check("R7 unexpected bit", EV_B0 + int'(bit_q), 0);
        else check("R5/R7 recovered bit", EV_B0 + int'(bit_q), evq.pop_front());
      end
      if (err_cnt != p_err) begin
        if (evq.size() == 0) check("R8 unexpected drop", EV_E, 0);
        else check("R8 drop counted", EV_E, evq.pop_front());
      end
      if (data_win) win_len++;
      if (!data_win && p_win) begin
        if (wq.size() == 0) check("R3 unexpected window", win_len, 0);
        else check("R3/R6 window length", win_len, wq.pop_front());
        win_len = 0;
      end
      p_clk = sep_clk; p_data = sep_data; p_win = data_win; p_err = err_cnt;
    end
  end

  task automatic pulse();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_clkwin();
    do @(negedge clk); while (!clk_win);
    @(negedge clk);
  endtask

  // one bit cell: clock pulse, optional data (early or in last window cycle),
  // optional pulse in the closing gap
  task automatic do_cell(input bit has_data, input bit late, input bit drop);
    int w;
    w = model_prev ? SHORT : LONG;
    wait_clkwin();
    evq.push_back(EV_C);
    wq.push_back((has_data && late) ? w + PULSE_LEN : w);
    pulse();
    do @(negedge clk); while (!data_win);
    if (has_data) begin
      evq.push_back(EV_D);
      evq.push_back(EV_B1);
      if (late) repeat (w - 3) @(negedge clk);
      pulse();
    end else begin
      evq.push_back(EV_B0);
      if (drop) begin
        if (model_err < (1 << ERR_W) - 1) begin
          evq.push_back(EV_E);
          model_err++;
        end
        repeat (w - 2) @(negedge clk);
        pulse();
      end
    end
    model_prev = has_data;
    wait_clkwin();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 clock window", int'(clk_win), 1);
    check("R1 data window", int'(data_win), 0);
    check("R1 separated pulses", int'(sep_clk || sep_data), 0);
    check("R1 bit strobe", int'(bit_valid), 0);
    check("R1 drop count", int'(err_cnt), 0);

    do_cell(0, 0, 0);  // R2 R3 long window after reset
    do_cell(1, 0, 0);  // R4 data in long window
    do_cell(1, 0, 0);  // R3 short window after a one
    do_cell(0, 0, 0);  // R5 mark cleared by clock
    do_cell(1, 1, 0);  // R6 late data, long window held
    do_cell(1, 1, 0);  // R6 late data, short window held
    do_cell(0, 0, 1);  // R8 pulse in the gap is dropped

    // R10: level held high across the cell gives one clock only
    wait_clkwin();
    evq.push_back(EV_C);
    wq.push_back(model_prev ? SHORT : LONG);
    evq.push_back(EV_B0);
    rd = 1'b1;
    repeat (30) @(negedge clk);
    rd = 1'b0;
    model_prev = 1'b0;

    do_cell(1, 0, 0);
    // R9: idle past the cell length restores the long window
    repeat (CELL + 12) @(negedge clk);
    model_prev = 1'b0;
    do_cell(0, 0, 0);

    repeat (4) do_cell(0, 0, 1);  // R8 saturation
    repeat (6) @(negedge clk);
    check("R8 counter saturated", int'(err_cnt), (1 << ERR_W) - 1);
    check("R2 all events seen", evq.size(), 0);
    check("R3 all windows seen", wq.size(), 0);
    done = 1'b1;
    report();
  end
endmodule